// File: doc/BRIEF.md
# Teletext request window generator

This block tells an external teletext data source when to deliver bits during a teletext line. It runs on the 27 MHz pixel clock. The line timing gives it a one-cycle start-of-window pulse and a qualifier that says whether the current line carries teletext. The block answers with a single request signal that is high for a window of pixel clocks, and the source streams its bits while the request is high.

An 8-bit trim value moves the two edges of the window independently, in whole pixel clocks. The upper nibble delays the rising edge after the start pulse. The lower nibble pulls the falling edge earlier than the nominal window end, which shortens the window and lowers the number of bits taken below the nominal count. A lower nibble of zero is a special case: the falling edge then moves with the rising edge, so the window length stays at the nominal value. The trim value and the qualifier are captured at the start pulse and held for the whole window.

Top module: `ttxw_req_gen`

## Requirements
- R1: After reset `ttx_req` is low and stays low until a start pulse opens a window.
- R2: Call the clock edge that samples `win_start` high E0. With rise trim r = `trim[7:4]`, `ttx_req` first goes high on edge E0+r.
- R3: With fall trim f = `trim[3:0]` nonzero, `ttx_req` goes low on edge E0+NOMINAL_LEN−f.
- R4: With f = 0, `ttx_req` goes low on edge E0+r+NOMINAL_LEN, so it is high for exactly NOMINAL_LEN clocks whatever r is.
- R5: If `line_ttx_en` is low on the edge E0, `ttx_req` stays low for that whole line.
- R6: If the computed falling time is not later than the rising time (NOMINAL_LEN−f ≤ r with f nonzero), `ttx_req` stays low for that line.
- R7: Changes on `trim` or `line_ttx_en` between start pulses have no effect on the window already open.
- R8: A start pulse during an open window restarts the timing from the new pulse, using the trim and qualifier sampled with it.
- R9: After the falling edge `ttx_req` stays low until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_ttx_en | input | 1 | High when the current line carries teletext; sampled with the start pulse |
| win_start | input | 1 | One-cycle start-of-window pulse from the line timing |
| trim | input | 8 | Edge trim: [7:4] rising-edge delay, [3:0] falling-edge advance, in clocks |
| ttx_req | output | 1 | Request to the teletext source; high during the window |

## Verification
The bench builds the block with NOMINAL_LEN = 20 in place of the full-line default, so one window plus the largest rising trim fits in under forty clocks. That makes a sweep over all 256 trim values affordable, both clean and with the trim and qualifier scrambled mid-window, and it brings the empty-window region (fall trim ≥ 20−rise) well inside the sweep, where a nominal length of a thousand clocks would never reach it.

// File: rtl/ttxw_pkg.sv
package ttxw_pkg;

    typedef struct packed {
        logic [3:0] rise;
        logic [3:0] fall;
    } ttxw_trim_t;

endpackage

// File: rtl/ttxw_edge_calc.sv
module ttxw_edge_calc
    import ttxw_pkg::*;
#(
    parameter int NOMINAL_LEN = 1400,
    parameter int CW          = 11
) (
    input  ttxw_trim_t    trim,
    output logic [CW-1:0] t_rise,
    output logic [CW-1:0] t_fall,
    output logic          valid
);

    localparam logic [CW-1:0] NOM_W = CW'(NOMINAL_LEN);

    logic [CW-1:0] fall_w;

    always_comb begin
        fall_w = CW'(trim.fall);
        t_rise = CW'(trim.rise);
        if (trim.fall == 4'd0) begin
            // falling edge tracks the rising edge: constant high time
            t_fall = t_rise + NOM_W;
        end else if (NOM_W > fall_w) begin
            t_fall = NOM_W - fall_w;
        end else begin
            t_fall = '0;
        end
        valid = (t_fall > t_rise);
    end

endmodule

// File: rtl/ttxw_window_ctr.sv
module ttxw_window_ctr #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          line_en,
    input  logic [CW-1:0] t_rise_in,
    input  logic [CW-1:0] t_fall_in,
    input  logic          valid_in,
    output logic          req
);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic [CW-1:0] t_rise;
        logic [CW-1:0] t_fall;
        logic          req;
    } win_state_t;

    win_state_t st_d, st_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + 1'b1;
        if (start) begin
            st_d.active = line_en && valid_in;
            st_d.cnt    = '0;
            st_d.t_rise = t_rise_in;
            st_d.t_fall = t_fall_in;
        end else if (st_q.active) begin
            st_d.cnt = cnt_inc;
            if (cnt_inc >= st_q.t_fall) begin
                st_d.active = 1'b0;
            end
        end
        st_d.req = st_d.active && (st_d.cnt >= st_d.t_rise)
                   && (st_d.cnt < st_d.t_fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

    p_no_req_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start && !line_en |=> !req);

    p_no_req_bad_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start && !valid_in |=> !req);

    p_rise_at_trim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> st_q.cnt == st_q.t_rise);

    p_req_inside_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> st_q.cnt < st_q.t_fall);

    p_snapshot_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(st_q.t_rise) && $stable(st_q.t_fall));

    p_quiet_after_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active && !start |=> !req);

endmodule

// File: rtl/ttxw_req_gen.sv
module ttxw_req_gen
    import ttxw_pkg::*;
#(
    parameter int NOMINAL_LEN = 1400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_ttx_en,
    input  logic       win_start,
    input  logic [7:0] trim,
    output logic       ttx_req
);

    localparam int CW = $clog2(NOMINAL_LEN + 17);

    ttxw_trim_t    trim_s;
    logic [CW-1:0] t_rise;
    logic [CW-1:0] t_fall;
    logic          valid;

    assign trim_s = ttxw_trim_t'(trim);

    ttxw_edge_calc #(
        .NOMINAL_LEN (NOMINAL_LEN),
        .CW          (CW)
    ) i_edge_calc (
        .trim   (trim_s),
        .t_rise (t_rise),
        .t_fall (t_fall),
        .valid  (valid)
    );

    ttxw_window_ctr #(
        .CW (CW)
    ) i_window_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (win_start),
        .line_en   (line_ttx_en),
        .t_rise_in (t_rise),
        .t_fall_in (t_fall),
        .valid_in  (valid),
        .req       (ttx_req)
    );

endmodule

// File: tb/test_ttxw_req_gen.sv
module test_ttxw_req_gen;

    localparam int NOM  = 20;
    localparam int SPAN = NOM + 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_ttx_en = 1'b0;
    logic       win_start = 1'b0;
    logic [7:0] trim = 8'h00;
    logic       ttx_req;

    int total = 0;
    int bad   = 0;

    ttxw_req_gen #(.NOMINAL_LEN(NOM)) i_ttxw_req_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_ttx_en (line_ttx_en),
        .win_start   (win_start),
        .trim        (trim),
        .ttx_req     (ttx_req)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic bit exp_req(bit en, logic [7:0] t, int k);
        int r, f;
        r = int'(t[7:4]);
        if (t[3:0] == 4'd0) f = r + NOM;
        else                f = NOM - int'(t[3:0]);
        return en && (f > r) && (k >= r) && (k < f);
    endfunction

    // Pulse start at a negedge, then compare ttx_req every negedge;
    // sample k follows edge E0+k.
    task automatic run_line(bit en, logic [7:0] t, bit scramble, string tag);
        bit ok = 1'b1;
        int bad_k = 0;
        bit act = 1'b0;
        bit ex  = 1'b0;
        win_start   = 1'b1;
        line_ttx_en = en;
        trim        = t;
        @(negedge clk);
        win_start = 1'b0;
        if (scramble) begin
            trim        = ~t;
            line_ttx_en = ~en;
        end
        for (int k = 0; k < SPAN; k++) begin
            if (ok && (ttx_req !== exp_req(en, t, k))) begin
                ok    = 1'b0;
                bad_k = k;
                act   = ttx_req;
                ex    = exp_req(en, t, k);
            end
            if (scramble && k == 5) trim = t ^ 8'h5a;
            @(negedge clk);
        end
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s trim=%02h en=%0d k=%0d: actual=%0d expected=%0d",
                     tag, t, en, bad_k, act, ex);
        end
    endtask

    task automatic check_low(int n, string tag);
        bit ok = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (ttx_req !== 1'b0) ok = 1'b0;
            @(negedge clk);
        end
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=1 expected=0", tag);
        end
    endtask

    function automatic string tag_of(bit en, logic [7:0] t);
        int r, f;
        r = int'(t[7:4]);
        f = (t[3:0] == 4'd0) ? r + NOM : NOM - int'(t[3:0]);
        if (!en)             return "R5";
        if (f <= r)          return "R6";
        if (t[3:0] == 4'd0)  return "R4";
        return "R2/R3";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: low after reset, with trim and enable set but no start
        line_ttx_en = 1'b1;
        trim        = 8'h00;
        check_low(12, "R1");

        // R2 R3 R4 R6: clean sweep over every trim value
        for (int t = 0; t < 256; t++) begin
            run_line(1'b1, 8'(t), 1'b0, tag_of(1'b1, 8'(t)));
        end

        // R7: same sweep with trim and enable scrambled mid-window
        for (int t = 0; t < 256; t++) begin
            run_line(1'b1, 8'(t), 1'b1, "R7");
        end

        // R5: qualifier low at start, with and without a later rise of it
        for (int t = 0; t < 256; t += 7) begin
            run_line(1'b0, 8'(t), t[0], "R5");
        end

        // R8: restart during an open window
        for (int j = 0; j < 4; j++) begin
            win_start   = 1'b1;
            line_ttx_en = 1'b1;
            trim        = 8'h20;
            @(negedge clk);
            win_start = 1'b0;
            repeat (4 + 3 * j) @(negedge clk);
            run_line(1'b1, 8'(8'h35 + 8'(j * 16)), 1'b0, "R8");
        end

        // R8: restart into a disabled line cuts the open window
        win_start   = 1'b1;
        trim        = 8'h10;
        @(negedge clk);
        win_start = 1'b0;
        repeat (6) @(negedge clk);
        run_line(1'b0, 8'h10, 1'b0, "R8");

        // R9: after a window closes, a long quiet stretch stays low
        run_line(1'b1, 8'hf0, 1'b0, "R4");
        line_ttx_en = 1'b1;
        check_low(60, "R9");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule